// File: doc/BRIEF.md
# Home-Node Cache Line Directory

This block is the directory at the home node of a cache-coherent, non-uniform memory machine. A request names the requesting node and a 32-bit physical address. The controller splits the address into a home-node field, a line field and a byte offset within a 64-byte line. It then consults a per-line entry that records whether some node caches the line and, if so, which node. Requests whose home field names another node are not served here. They are returned at once, marked for forwarding to that node.

For a local line, the controller first recalls the line from a different holder when there is one. It sends an invalidate and waits for the acknowledgment. It then reads the line from local memory, which answers with a variable latency. It hands the data back to the requester and records the requester as the new single holder. The controller works on one request at a time and stalls its request input while busy. Every output channel uses a valid/ready or valid/acknowledge handshake.

Top module: `coh_home_dir`

## Requirements
- R1: The home node is address bits [31:24], the line is bits [23:6], and bits [5:0] are the byte offset. The offset never changes the outcome. The directory is indexed by the low IDX_W bits of the line field, so lines that agree in those bits share one entry.
- R2: After reset every entry is uncached. The first request to any local line issues no invalidate, and the outputs are idle with req_ready high.
- R3: A local request issues exactly one memory read whose line equals the address line field. After the read data arrives, the controller replies with rsp_fwd=0, rsp_dest equal to the requester, and rsp_data equal to the returned data.
- R4: Serving a local request marks its entry cached with the requester's node ID. An entry stays cached until reset.
- R5: A request whose home field differs from LOCAL_NODE is answered with rsp_fwd=1, rsp_dest equal to that home field, and rsp_data zero. It causes no memory read, no invalidate and no directory change.
- R6: When a local line is cached by a node other than the requester, the controller raises inv_valid with inv_node set to the old holder and inv_line set to the line field. It holds these until inv_ack, and it starts the memory read only after the acknowledgment.
- R7: When the requester already holds the line, no invalidate is issued and the line is read and returned again.
- R8: Only one request is in flight. req_ready is high only while idle, so no request is accepted between an accept and the matching reply handshake.
- R9: mem_req, inv and rsp outputs stay asserted and unchanged until their handshake completes (mem_req_ready, inv_ack, rsp_ready).
- R10: The reply waits for mem_rsp_valid whatever the memory latency, and rsp_src always carries the requester's ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_src | input | NODE_W | Requesting node ID |
| req_addr | input | ADDR_W | Physical address |
| mem_req_valid | output | 1 | Local memory line read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_line | output | LINE_W | Line number to read |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | DATA_W | Line data |
| inv_valid | output | 1 | Invalidate to old holder |
| inv_ack | input | 1 | Old holder acknowledged |
| inv_node | output | NODE_W | Node to invalidate |
| inv_line | output | LINE_W | Line to invalidate |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Reply taken |
| rsp_fwd | output | 1 | 1: forward to rsp_dest home node, 0: data reply |
| rsp_dest | output | NODE_W | Destination node |
| rsp_src | output | NODE_W | Original requester |
| rsp_line | output | LINE_W | Line field of the request |
| rsp_data | output | DATA_W | Line data (zero when forwarded) |

## Verification
On every cycle, the assertions check three things: each output holds its value while its handshake is pending, no second request is accepted right after an accept, and entries never lose the cached state. They also check that an acknowledged invalidate leads straight into a memory read, and that arriving memory data appears in the very next reply. Only the bench scenarios can show which node is invalidated and when. Those scenarios first fill every entry and then take the lines over from a second node, including aliased line numbers. They also cover re-requests by the current holder and foreign addresses that must leave the directory untouched. Memory latencies vary, and the bench compares reply data against the values it computes itself.

// File: rtl/coh_home_dir_pkg.sv
// Shared types for the home-node directory controller.
package coh_home_dir_pkg;

    // Controller phases; one request is in flight at a time.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_INVAL  = 3'd2,
        ST_FETCH  = 3'd3,
        ST_REPLY  = 3'd4
    } hd_state_t;

endpackage

// File: rtl/coh_addr_fields.sv
// Splits a physical address into home node, line number and byte offset.
// Assumes ADDR_W = NODE_W + LINE_W + OFFS_W, node in the top bits.
module coh_addr_fields #(
    parameter int ADDR_W = 32,
    parameter int NODE_W = 8,
    parameter int OFFS_W = 6,
    parameter int LINE_W = ADDR_W - NODE_W - OFFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NODE_W-1:0] node,
    output logic [LINE_W-1:0] line,
    output logic [OFFS_W-1:0] offs
);
    // Pure field extraction, no state.
    assign node = addr[ADDR_W-1 -: NODE_W];
    assign line = addr[OFFS_W +: LINE_W];
    assign offs = addr[OFFS_W-1:0];
endmodule

// File: rtl/coh_dir_table.sv
// Directory storage: one entry per tracked line, a cached flag plus holder ID.
// Assumes a single writer; reads are combinational; reset clears every entry.
module coh_dir_table #(
    parameter int NODE_W = 8,
    parameter int IDX_W  = 4,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_cached,
    output logic [NODE_W-1:0] rd_holder,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [NODE_W-1:0] wr_holder
);
    logic [DEPTH-1:0] cached_q;
    logic [NODE_W-1:0] holder_q [DEPTH];

    // Entry update: reset to uncached, otherwise record the new holder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cached_q[i] <= 1'b0;
                holder_q[i] <= '0;
            end
        end else if (wr_en) begin
            cached_q[wr_idx] <= 1'b1;
            holder_q[wr_idx] <= wr_holder;
        end
    end

    // Lookup port.
    assign rd_cached = cached_q[rd_idx];
    assign rd_holder = holder_q[rd_idx];

    // Per-entry check that a cached line stays cached until reset.
    for (genvar g = 0; g < DEPTH; g++) begin : g_sticky
        assert_entry_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
            cached_q[g] |=> cached_q[g]);
    end
endmodule

// File: rtl/coh_home_dir.sv
// Home-node directory controller. Serves one request at a time:
// foreign home field -> forwarded reply; local line -> optional invalidate of
// a different holder, memory read, data reply, holder recorded.
// Assumes mem_rsp_valid pulses once per accepted read and inv_ack once per invalidate.
module coh_home_dir
    import coh_home_dir_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          NODE_W     = 8,
    parameter int          OFFS_W     = 6,
    parameter int          IDX_W      = 4,
    parameter int          DATA_W     = 64,
    parameter int unsigned LOCAL_NODE = 36,
    localparam int LINE_W = ADDR_W - NODE_W - OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [NODE_W-1:0] req_src,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [LINE_W-1:0] mem_req_line,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              inv_valid,
    input  logic              inv_ack,
    output logic [NODE_W-1:0] inv_node,
    output logic [LINE_W-1:0] inv_line,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fwd,
    output logic [NODE_W-1:0] rsp_dest,
    output logic [NODE_W-1:0] rsp_src,
    output logic [LINE_W-1:0] rsp_line,
    output logic [DATA_W-1:0] rsp_data
);
    localparam logic [NODE_W-1:0] HOME_ID = NODE_W'(LOCAL_NODE);

    hd_state_t         st_q;
    logic [NODE_W-1:0] src_q, node_q, old_q;
    logic [LINE_W-1:0] line_q;
    logic [DATA_W-1:0] data_q;
    logic              fwd_q, issued_q;

    logic [NODE_W-1:0] f_node;
    logic [LINE_W-1:0] f_line;
    logic [OFFS_W-1:0] offs_unused;
    logic              tbl_cached, tbl_wr;
    logic [NODE_W-1:0] tbl_holder;

    coh_addr_fields #(
        .ADDR_W(ADDR_W), .NODE_W(NODE_W), .OFFS_W(OFFS_W), .LINE_W(LINE_W)
    ) u_fields (
        .addr(req_addr), .node(f_node), .line(f_line), .offs(offs_unused)
    );

    coh_dir_table #(.NODE_W(NODE_W), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (line_q[IDX_W-1:0]),
        .rd_cached (tbl_cached),
        .rd_holder (tbl_holder),
        .wr_en     (tbl_wr),
        .wr_idx    (line_q[IDX_W-1:0]),
        .wr_holder (src_q)
    );

    // Table is written when the line data arrives for a local request.
    assign tbl_wr = (st_q == ST_FETCH) && issued_q && mem_rsp_valid;

    // Request sequencing through lookup, invalidate, fetch and reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            src_q    <= '0;
            node_q   <= '0;
            old_q    <= '0;
            line_q   <= '0;
            data_q   <= '0;
            fwd_q    <= 1'b0;
            issued_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    src_q  <= req_src;
                    node_q <= f_node;
                    line_q <= f_line;
                    st_q   <= ST_LOOKUP;
                end
                ST_LOOKUP: begin
                    issued_q <= 1'b0;
                    if (node_q != HOME_ID) begin
                        fwd_q  <= 1'b1;
                        data_q <= '0;
                        st_q   <= ST_REPLY;
                    end else begin
                        fwd_q <= 1'b0;
                        old_q <= tbl_holder;
                        st_q  <= (tbl_cached && tbl_holder != src_q) ? ST_INVAL : ST_FETCH;
                    end
                end
                ST_INVAL: if (inv_ack) st_q <= ST_FETCH;
                ST_FETCH: begin
                    if (!issued_q && mem_req_ready) issued_q <= 1'b1;
                    if (issued_q && mem_rsp_valid) begin
                        data_q <= mem_rsp_data;
                        st_q   <= ST_REPLY;
                    end
                end
                ST_REPLY: if (rsp_ready) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Channel outputs decoded from the phase and captured request.
    assign req_ready     = (st_q == ST_IDLE);
    assign mem_req_valid = (st_q == ST_FETCH) && !issued_q;
    assign mem_req_line  = line_q;
    assign inv_valid     = (st_q == ST_INVAL);
    assign inv_node      = old_q;
    assign inv_line      = line_q;
    assign rsp_valid     = (st_q == ST_REPLY);
    assign rsp_fwd       = fwd_q;
    assign rsp_dest      = fwd_q ? node_q : src_q;
    assign rsp_src       = src_q;
    assign rsp_line      = line_q;
    assign rsp_data      = data_q;

    assert_one_in_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_line));
    assert_inv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ack) |=> inv_valid && $stable(inv_node) && $stable(inv_line));
    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_dest) && $stable(rsp_data)
                                      && $stable(rsp_fwd) && $stable(rsp_line));
    assert_ack_then_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_ack) |=> mem_req_valid);
    assert_data_to_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr |=> rsp_valid && !rsp_fwd && rsp_data == $past(mem_rsp_data));
    assert_fwd_foreign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fwd) |-> rsp_dest != HOME_ID);
endmodule

// File: tb/coh_home_dir_bench.sv
// Bench: sweeps every directory entry through fill, takeover, re-request and
// foreign-address cases, modelling memory and the old holder at the ports.
module coh_home_dir_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32, NODE_W = 8, OFFS_W = 6, IDX_W = 4, DATA_W = 64;
    localparam int LINE_W = ADDR_W - NODE_W - OFFS_W;
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [NODE_W-1:0] HOME = 8'd36;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic inv_ack = 1'b0, rsp_ready = 1'b0;
    logic [NODE_W-1:0] req_src = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] mem_rsp_data = '0;
    logic req_ready, mem_req_valid, inv_valid, rsp_valid, rsp_fwd;
    logic [LINE_W-1:0] mem_req_line, inv_line, rsp_line;
    logic [NODE_W-1:0] inv_node, rsp_dest, rsp_src;
    logic [DATA_W-1:0] rsp_data;

    int errors = 0, checks = 0, cycles = 0;
    logic              m_cached [DEPTH];
    logic [NODE_W-1:0] m_holder [DEPTH];

    coh_home_dir u_coh_home_dir (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_addr(req_addr), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_line(mem_req_line),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .inv_valid(inv_valid), .inv_ack(inv_ack), .inv_node(inv_node),
        .inv_line(inv_line), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_fwd(rsp_fwd), .rsp_dest(rsp_dest), .rsp_src(rsp_src),
        .rsp_line(rsp_line), .rsp_data(rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DATA_W-1:0] line_data(input logic [LINE_W-1:0] ln);
        return (64'(ln) * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0F0F_5A5A_0000_1234;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // One request end to end; expectations come from the bench's own directory model.
    task automatic serve(input logic [NODE_W-1:0] src, input logic [NODE_W-1:0] node,
                         input logic [LINE_W-1:0] ln, input logic [OFFS_W-1:0] off, input int lat);
        int idx = int'(ln[IDX_W-1:0]);
        bit exp_fwd = (node != HOME);
        bit exp_inv = !exp_fwd && m_cached[idx] && (m_holder[idx] != src);
        logic [NODE_W-1:0] exp_old = m_holder[idx];
        int inv_cyc = 0, acks = 0, mem_cnt = 0, cnt = 0, rsp_seen = 0;
        int busy_bad = 0, order_bad = 0, stab_bad = 0;
        bit done = 0, ack_set = 0;
        logic [LINE_W-1:0] mem_ln = '0, inv_ln = '0;
        logic [NODE_W-1:0] inv_nd = '0;
        logic [DATA_W-1:0] first_data = '0;
        logic [NODE_W-1:0] first_dest = '0;
        @(negedge clk);
        req_valid = 1'b1; req_src = src; req_addr = {node, ln, off};
        @(negedge clk);
        req_valid = 1'b0; req_addr = '0;
        for (int t = 0; t < 300 && !done; t++) begin
            if (req_ready) busy_bad++;
            if (ack_set) begin inv_ack = 1'b0; ack_set = 0; acks++; end
            if (inv_valid) begin
                inv_cyc++; inv_nd = inv_node; inv_ln = inv_line;
                if (inv_cyc == 2) begin inv_ack = 1'b1; ack_set = 1; end
            end
            mem_rsp_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = line_data(mem_ln); end
            end
            mem_req_ready = 1'b0;
            if (mem_req_valid) begin
                if (exp_inv && acks == 0) order_bad++;
                if ((t % 2) == 1) begin
                    mem_req_ready = 1'b1; mem_cnt++; mem_ln = mem_req_line; cnt = lat;
                end
            end
            rsp_ready = 1'b0;
            if (rsp_valid) begin
                rsp_seen++;
                if (rsp_seen == 1) begin first_data = rsp_data; first_dest = rsp_dest; end
                else begin
                    if (rsp_data != first_data || rsp_dest != first_dest) stab_bad++;
                    rsp_ready = 1'b1; done = 1;
                end
            end
            @(negedge clk);
        end
        rsp_ready = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
        check(done, "R10 reply seen", 64'(done), 64'd1);
        check(rsp_fwd == exp_fwd, "R5 forward flag", 64'(rsp_fwd), 64'(exp_fwd));
        check(first_dest == (exp_fwd ? node : src), "R3/R5 destination", 64'(first_dest), 64'(exp_fwd ? node : src));
        check(rsp_src == src, "R10 requester id", 64'(rsp_src), 64'(src));
        check(rsp_line == ln, "R1 line field", 64'(rsp_line), 64'(ln));
        check(first_data == (exp_fwd ? '0 : line_data(ln)), "R3 reply data", first_data, exp_fwd ? '0 : line_data(ln));
        check(mem_cnt == (exp_fwd ? 0 : 1), "R3/R5 memory read count", 64'(mem_cnt), 64'(exp_fwd ? 0 : 1));
        if (!exp_fwd) check(mem_ln == ln, "R3 memory read line", 64'(mem_ln), 64'(ln));
        check((inv_cyc > 0) == exp_inv, "R2/R6/R7 invalidate issued", 64'(inv_cyc > 0), 64'(exp_inv));
        if (exp_inv) begin
            check(inv_nd == exp_old, "R6 invalidate node", 64'(inv_nd), 64'(exp_old));
            check(inv_ln == ln, "R6 invalidate line", 64'(inv_ln), 64'(ln));
            check(inv_cyc == 2, "R9 invalidate held until ack", 64'(inv_cyc), 64'd2);
        end
        check(order_bad == 0, "R6 read after ack", 64'(order_bad), 64'd0);
        check(busy_bad == 0, "R8 no accept while busy", 64'(busy_bad), 64'd0);
        check(stab_bad == 0, "R9 reply stable", 64'(stab_bad), 64'd0);
        if (!exp_fwd) begin m_cached[idx] = 1'b1; m_holder[idx] = src; end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_cached[i] = 1'b0; m_holder[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: idle outputs after reset
        check(req_ready == 1'b1, "R2 req_ready after reset", 64'(req_ready), 64'd1);
        check(!rsp_valid && !inv_valid && !mem_req_valid, "R2 idle outputs",
              64'({rsp_valid, inv_valid, mem_req_valid}), 64'd0);
        // R2/R3/R4: fill every entry from node 5, offsets varied (R1)
        for (int i = 0; i < DEPTH; i++)
            serve(8'd5, HOME, LINE_W'(i), OFFS_W'(i * 5), 1 + (i % 4));
        // R1/R6: aliasing lines taken over by node 7
        for (int i = 0; i < DEPTH; i++)
            serve(8'd7, HOME, LINE_W'(i + DEPTH * (i + 1)), OFFS_W'(63 - i), 1 + ((i + 1) % 4));
        // R7: current holder re-requests
        for (int i = 0; i < DEPTH; i += 2)
            serve(8'd7, HOME, LINE_W'(i), OFFS_W'(i), 3);
        // R5: foreign home fields leave the directory alone
        for (int i = 0; i < 4; i++)
            serve(8'd9, HOME ^ NODE_W'(i + 1), LINE_W'(i), OFFS_W'(0), 1);
        // R5/R6: node 9 then finds node 7 still recorded
        serve(8'd9, HOME, LINE_W'(1), OFFS_W'(8), 2);
        serve(8'd5, HOME, LINE_W'(1), OFFS_W'(8), 4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule